// File: doc/BRIEF.md
# Banked Overflow-Count Register Window

This block keeps a 24-bit count of overflow pulses coming from a 16-bit base timer. Each pulse moves the count forward by one. When the incremented count equals a programmable period, the count returns to zero and a period strobe fires. Two programmable compare values each produce their own strobe when the count lands on them. A capture strobe copies the running count into a capture register.

Software reaches the block through an 8-bit byte window with a 2-bit byte index. A 3-bit bank code picks which 24-bit quantity the window shows. Reading the low byte of the live count freezes the two upper bytes in a shadow latch, so a byte-by-byte read returns one consistent value. Writes are staged. Low and middle bytes go into shared holding registers. The selected target changes only when its high byte is written, so all 24 bits change in the same cycle.

The base timer and the interrupt controller lie outside the block. They appear here only as the overflow pulse input and the three strobe outputs.

Top module: `ovfw_top`

## Requirements
- R1: After reset the live count, capture register and shadow latch are zero, the period and both compare values are 0xFFFFFF, and no strobe is high.
- R2: The live count rises by exactly one on each clock edge where `ovf_tick_i` is high, and holds its value on every other edge unless a live commit occurs.
- R3: When `ovf_tick_i` is high and count+1 equals the period, `period_evt_o` is high in that cycle and the count becomes 0 at the next edge. Otherwise `period_evt_o` is low.
- R4: When `ovf_tick_i` is high, `cmp1_evt_o` is high in the cycles where the count's next value (0 after a period wrap) equals compare 1. `cmp2_evt_o` behaves the same way against compare 2.
- R5: With bank 000, a read (`rd_en_i`) at byte index 0 returns live count bits 7:0 and latches live bits 23:8 into the shadow. Byte indices 1 and 2 of bank 000 return shadow bits 15:8 and 23:16, and later counting does not change them.
- R6: Writes at byte index 0 or 1 go only to shared staging registers and leave every target unchanged. A write at byte index 2 loads {data, staged byte 1, staged byte 0} into the bank's target in one edge.
- R7: Bank codes are 000 live count, 001 capture (read-only), 010 period, 011 compare 1 and 100 compare 2. Codes 101–111 and byte index 3 read as zero, and commits to them or to bank 001 change nothing.
- R8: On an edge where `capture_i` is high, the capture register takes the live count value from before that edge.
- R9: A commit to the live count on an edge where `ovf_tick_i` is also high loads the written value. No strobe fires in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ovf_tick_i | input | 1 | Base timer overflow pulse, advances the count |
| capture_i | input | 1 | Capture strobe, copies the live count |
| bank_i | input | 3 | Bank code selecting the window target |
| byte_idx_i | input | 2 | Byte index within the window (0 = bits 7:0) |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Byte read strobe (arms the shadow latch) |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte, combinational from the bank and byte index |
| period_evt_o | output | 1 | Period wrap strobe |
| cmp1_evt_o | output | 1 | Compare 1 strobe |
| cmp2_evt_o | output | 1 | Compare 2 strobe |

## Verification
The count is driven with sparse and irregular overflow pulses, so that the bench can tell counting on the pulse apart from counting on the clock. It is then driven with back-to-back pulses across a small period, where wrap timing and compare hits on the post-wrap value both show. A byte read of the live count is split by several pulses, and a carry is arranged to move the upper bytes, so that a missing or late shadow latch shows up. Partial writes are followed by reads, writes go to the capture bank and unused bank codes, and a commit lands together with a pulse, to separate staging, ignored writes and write priority.

// File: rtl/ovfw_pkg.sv
// Package ovfw_pkg
// Shared bank codes for the overflow-count register window.
// Assumes a 3-bit bank field; codes not listed here are unused.
package ovfw_pkg;
    typedef enum logic [2:0] {
        BANK_LIVE = 3'd0,
        BANK_CAPT = 3'd1,
        BANK_PER  = 3'd2,
        BANK_CMP1 = 3'd3,
        BANK_CMP2 = 3'd4
    } bank_e;
endpackage

// File: rtl/ovfw_regs.sv
// Module ovfw_regs
// Staging registers for the byte-serial write path, plus the period
// and compare targets. Low-order bytes land in staging registers that
// all banks share. A write to the top byte commits the full word to the
// selected target, or hands it to the counter when the live bank is
// selected. Assumes CNT_W is a multiple of BYTE_W and at least two
// bytes wide.
module ovfw_regs
    import ovfw_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int BYTE_W = 8,
    parameter int AW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bank_i,
    input  logic [AW-1:0]     byte_idx_i,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  period_o,
    output logic [CNT_W-1:0]  cmp1_o,
    output logic [CNT_W-1:0]  cmp2_o,
    output logic              live_wr_o,
    output logic [CNT_W-1:0]  live_val_o
);
    localparam int NBYTES = CNT_W / BYTE_W;
    localparam logic [AW-1:0] TOP_IDX = AW'(NBYTES - 1);

    logic [NBYTES-2:0][BYTE_W-1:0] stage_q;
    logic                          commit;
    logic [CNT_W-1:0]              commit_val;

    // One staging byte per low-order byte position.
    for (genvar b = 0; b < NBYTES - 1; b++) begin : g_stage
        // Capture a low-order byte write for a later commit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage_q[b] <= '0;
            else if (wr_en_i && byte_idx_i == AW'(b))
                stage_q[b] <= wdata_i;
        end
    end

    // Build the committed word from the top byte and the staged bytes.
    always_comb begin
        commit     = wr_en_i && (byte_idx_i == TOP_IDX);
        commit_val = {wdata_i, stage_q};
        live_wr_o  = commit && (bank_i == BANK_LIVE);
        live_val_o = commit_val;
    end

    // Update the period and compare targets on a top-byte commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_o <= '1;
            cmp1_o   <= '1;
            cmp2_o   <= '1;
        end else if (commit) begin
            if (bank_i == BANK_PER)  period_o <= commit_val;
            if (bank_i == BANK_CMP1) cmp1_o   <= commit_val;
            if (bank_i == BANK_CMP2) cmp2_o   <= commit_val;
        end
    end

    // R6: a low-order byte write leaves every target unchanged.
    assert_partial_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && byte_idx_i != TOP_IDX) |=>
            ($stable(period_o) && $stable(cmp1_o) && $stable(cmp2_o)));

    // R6: a period commit loads the staged word in one edge.
    assert_period_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && bank_i == BANK_PER) |=> (period_o == $past(commit_val)));

    // R7: a commit to an unused or read-only bank changes no target.
    assert_bad_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && bank_i != BANK_PER && bank_i != BANK_CMP1 && bank_i != BANK_CMP2) |=>
            ($stable(period_o) && $stable(cmp1_o) && $stable(cmp2_o)));
endmodule

// File: rtl/ovfw_core.sv
// Module ovfw_core
// The overflow counter. It advances on each base-timer pulse, returns
// to zero when the incremented value equals the period, and raises
// period and compare strobes in the same cycle as the transition. A
// live commit takes priority over a pulse and suppresses the strobes.
// Also holds the capture register. Assumes the strobes are sampled by
// logic downstream on the same clock.
module ovfw_core #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             capture_i,
    input  logic             live_wr_i,
    input  logic [CNT_W-1:0] live_val_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] cmp1_i,
    input  logic [CNT_W-1:0] cmp2_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cap_o,
    output logic             period_evt_o,
    output logic             cmp1_evt_o,
    output logic             cmp2_evt_o
);
    logic [CNT_W-1:0] incr;
    logic [CNT_W-1:0] next_cnt;
    logic             hit_period;
    logic             advance;

    // Work out the next count and the strobes raised by this pulse.
    always_comb begin
        incr         = cnt_o + CNT_W'(1);
        hit_period   = (incr == period_i);
        next_cnt     = hit_period ? '0 : incr;
        advance      = tick_i && !live_wr_i;
        period_evt_o = advance && hit_period;
        cmp1_evt_o   = advance && (next_cnt == cmp1_i);
        cmp2_evt_o   = advance && (next_cnt == cmp2_i);
    end

    // Counter register: commit first, then advance on a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (live_wr_i)
            cnt_o <= live_val_i;
        else if (tick_i)
            cnt_o <= next_cnt;
    end

    // Capture register: snapshot of the count on a capture strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_o <= '0;
        else if (capture_i)
            cap_o <= cnt_o;
    end

    // R1: reset clears the count.
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (cnt_o == '0 && cap_o == '0));

    // R2: no pulse and no commit means the count holds.
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !live_wr_i) |=> $stable(cnt_o));

    // R3: the period strobe is followed by a count of zero.
    assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        period_evt_o |=> (cnt_o == '0));

    // R3: no strobe is raised without a pulse.
    assert_evt_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (period_evt_o || cmp1_evt_o || cmp2_evt_o) |-> tick_i);

    // R4: a compare strobe lands the count on that compare value.
    assert_cmp1_land_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp1_evt_o |=> (cnt_o == $past(cmp1_i)));
    assert_cmp2_land_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp2_evt_o |=> (cnt_o == $past(cmp2_i)));

    // R8: the capture register only moves on a capture strobe.
    assert_cap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> $stable(cap_o));

    // R9: a live commit wins and no strobe fires with it.
    assert_commit_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        live_wr_i |-> !(period_evt_o || cmp1_evt_o || cmp2_evt_o));
endmodule

// File: rtl/ovfw_rdmux.sv
// Module ovfw_rdmux
// Read side of the window: the shadow latch for the live count's upper
// bytes, and the byte mux over all banks. The read data is
// combinational. A read strobe only arms the shadow latch. Assumes
// CNT_W is a multiple of BYTE_W.
module ovfw_rdmux
    import ovfw_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int BYTE_W = 8,
    parameter int AW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bank_i,
    input  logic [AW-1:0]     byte_idx_i,
    input  logic              rd_en_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CNT_W-1:0]  cap_i,
    input  logic [CNT_W-1:0]  period_i,
    input  logic [CNT_W-1:0]  cmp1_i,
    input  logic [CNT_W-1:0]  cmp2_i,
    output logic [BYTE_W-1:0] rdata_o
);
    localparam int NBYTES = CNT_W / BYTE_W;
    localparam int SHW    = CNT_W - BYTE_W;

    logic [SHW-1:0]   shadow_q;
    logic             latch_rd;
    logic [CNT_W-1:0] view;

    // Decode the read that arms the shadow latch.
    always_comb latch_rd = rd_en_i && (bank_i == BANK_LIVE) && (byte_idx_i == '0);

    // Shadow latch for the live count's upper bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (latch_rd)
            shadow_q <= cnt_i[CNT_W-1:BYTE_W];
    end

    // Pick the 24-bit view for the bank, then the addressed byte.
    always_comb begin
        case (bank_i)
            BANK_LIVE: view = {shadow_q, cnt_i[BYTE_W-1:0]};
            BANK_CAPT: view = cap_i;
            BANK_PER:  view = period_i;
            BANK_CMP1: view = cmp1_i;
            BANK_CMP2: view = cmp2_i;
            default:   view = '0;
        endcase
        rdata_o = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (byte_idx_i == AW'(b))
                rdata_o = view[b*BYTE_W +: BYTE_W];
        end
    end

    // R5: a low-byte read of the live bank latches the upper bytes.
    assert_shadow_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        latch_rd |=> (shadow_q == $past(cnt_i[CNT_W-1:BYTE_W])));

    // R5: without such a read the shadow stays put.
    assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_rd |=> $stable(shadow_q));
endmodule

// File: rtl/ovfw_top.sv
// Module ovfw_top
// Banked overflow-count window. The staging and target registers, the
// counter core and the read mux are joined here. Assumes one clock
// domain and pulse inputs that last one cycle each.
module ovfw_top #(
    parameter int CNT_W  = 24,
    parameter int BYTE_W = 8,
    parameter int AW     = $clog2(CNT_W / BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovf_tick_i,
    input  logic              capture_i,
    input  logic [2:0]        bank_i,
    input  logic [AW-1:0]     byte_idx_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              period_evt_o,
    output logic              cmp1_evt_o,
    output logic              cmp2_evt_o
);
    logic [CNT_W-1:0] period_w;
    logic [CNT_W-1:0] cmp1_w;
    logic [CNT_W-1:0] cmp2_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] cap_w;
    logic [CNT_W-1:0] live_val_w;
    logic             live_wr_w;

    ovfw_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_i     (bank_i),
        .byte_idx_i (byte_idx_i),
        .wr_en_i    (wr_en_i),
        .wdata_i    (wdata_i),
        .period_o   (period_w),
        .cmp1_o     (cmp1_w),
        .cmp2_o     (cmp2_w),
        .live_wr_o  (live_wr_w),
        .live_val_o (live_val_w)
    );

    ovfw_core #(.CNT_W(CNT_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (ovf_tick_i),
        .capture_i    (capture_i),
        .live_wr_i    (live_wr_w),
        .live_val_i   (live_val_w),
        .period_i     (period_w),
        .cmp1_i       (cmp1_w),
        .cmp2_i       (cmp2_w),
        .cnt_o        (cnt_w),
        .cap_o        (cap_w),
        .period_evt_o (period_evt_o),
        .cmp1_evt_o   (cmp1_evt_o),
        .cmp2_evt_o   (cmp2_evt_o)
    );

    ovfw_rdmux #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .AW(AW)) u_rdmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_i     (bank_i),
        .byte_idx_i (byte_idx_i),
        .rd_en_i    (rd_en_i),
        .cnt_i      (cnt_w),
        .cap_i      (cap_w),
        .period_i   (period_w),
        .cmp1_i     (cmp1_w),
        .cmp2_i     (cmp2_w),
        .rdata_o    (rdata_o)
    );
endmodule

// File: tb/ovfw_top_bench.sv
// Bench for ovfw_top: a behavioural reference model compared on every clock.
module ovfw_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MASK = 24'hFFFFFF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       capture = 1'b0;
    logic [2:0] bank = 3'd0;
    logic [1:0] bidx = 2'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       pevt, c1evt, c2evt;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    // reference model state
    int m_cnt, m_cap, m_shadow, m_per, m_c1, m_c2, m_s0, m_s1;

    always #(CLK_PERIOD/2) clk = ~clk;

    ovfw_top u_ovfw_top (
        .clk(clk), .rst_n(rst_n), .ovf_tick_i(tick), .capture_i(capture),
        .bank_i(bank), .byte_idx_i(bidx), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .wdata_i(wdata), .rdata_o(rdata), .period_evt_o(pevt),
        .cmp1_evt_o(c1evt), .cmp2_evt_o(c2evt)
    );

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic int byte_of(int v, int i);
        return (v >> (8 * i)) & 8'hFF;
    endfunction

    function automatic int exp_rdata();
        int view;
        if (bidx == 2'd3) return 0;
        case (bank)
            3'd0: view = (m_shadow << 8) | (m_cnt & 8'hFF);
            3'd1: view = m_cap;
            3'd2: view = m_per;
            3'd3: view = m_c1;
            3'd4: view = m_c2;
            default: view = 0;
        endcase
        return byte_of(view, int'(bidx));
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_cap = 0; m_shadow = 0;
        m_per = MASK; m_c1 = MASK; m_c2 = MASK; m_s0 = 0; m_s1 = 0;
    endtask

    // One clock: compare outputs, then advance the model at the edge.
    task automatic cyc();
        bit commit, live_commit, hit;
        int nxt, wrapped, newval;
        #1;
        commit      = wr_en && bidx == 2'd2;
        live_commit = commit && bank == 3'd0;
        nxt         = (m_cnt + 1) & MASK;
        hit         = (nxt == m_per);
        wrapped     = hit ? 0 : nxt;
        newval      = (int'(wdata) << 16) | (m_s1 << 8) | m_s0;
        chk(cur_req, "rdata", int'(rdata), exp_rdata());
        chk("R3", "period_evt", int'(pevt), int'(tick && !live_commit && hit));
        chk("R4", "cmp1_evt", int'(c1evt), int'(tick && !live_commit && wrapped == m_c1));
        chk("R4", "cmp2_evt", int'(c2evt), int'(tick && !live_commit && wrapped == m_c2));
        @(posedge clk);
        if (capture) m_cap = m_cnt;
        if (rd_en && bank == 3'd0 && bidx == 2'd0) m_shadow = m_cnt >> 8;
        if (live_commit) m_cnt = newval;
        else if (tick) m_cnt = wrapped;
        if (commit && bank == 3'd2) m_per = newval;
        if (commit && bank == 3'd3) m_c1 = newval;
        if (commit && bank == 3'd4) m_c2 = newval;
        if (wr_en && bidx == 2'd0) m_s0 = int'(wdata);
        if (wr_en && bidx == 2'd1) m_s1 = int'(wdata);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; capture = 1'b0;
        bank = 3'd0; bidx = 2'd0;
    endtask

    task automatic wrb(int b, int i, int d);
        bank = 3'(b); bidx = 2'(i); wdata = 8'(d); wr_en = 1'b1;
        cyc();
    endtask

    task automatic wr24(int b, int v);
        wrb(b, 0, byte_of(v, 0));
        wrb(b, 1, byte_of(v, 1));
        wrb(b, 2, byte_of(v, 2));
    endtask

    task automatic rdb(int b, int i);
        bank = 3'(b); bidx = 2'(i); rd_en = 1'b1;
        cyc();
    endtask

    task automatic run(int n, bit t);
        for (int k = 0; k < n; k++) begin
            tick = t;
            cyc();
        end
        tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every bank reads its reset value
        cur_req = "R1";
        for (int b = 0; b < 5; b++)
            for (int i = 0; i < 3; i++) rdb(b, i);

        // R2: sparse, irregular pulses
        cur_req = "R2";
        for (int k = 0; k < 12; k++) begin
            tick = (k % 3 != 1);
            cyc();
        end
        tick = 1'b0;
        run(3, 1'b0);

        // R6: partial writes leave the period untouched
        cur_req = "R6";
        wrb(2, 0, 8'h07);
        wrb(2, 1, 8'h00);
        run(2, 1'b1);
        rdb(2, 0); rdb(2, 1); rdb(2, 2);
        wrb(2, 2, 8'h00);
        rdb(2, 0); rdb(2, 2);

        // R4: program compares and run back-to-back pulses across wraps
        cur_req = "R4";
        wr24(3, 3);
        wr24(4, 0);
        cur_req = "R3";
        run(20, 1'b1);

        // R5: latched upper bytes stay fixed while a carry moves the count
        cur_req = "R5";
        wr24(2, MASK);
        wr24(0, 24'h01FFFD);
        rdb(0, 0);
        run(5, 1'b1);
        rdb(0, 1); rdb(0, 2);
        rdb(0, 0); rdb(0, 1); rdb(0, 2);

        // R3: wrap at the all-ones period
        cur_req = "R3";
        wr24(0, 24'hFFFFFC);
        run(4, 1'b1);

        // R8: capture while counting
        cur_req = "R8";
        run(3, 1'b1);
        capture = 1'b1; tick = 1'b1;
        cyc();
        tick = 1'b0;
        rdb(1, 0); rdb(1, 1); rdb(1, 2);

        // R7: read-only and unused banks, byte index 3
        cur_req = "R7";
        wr24(1, 24'hABCDEF);
        rdb(1, 0); rdb(1, 2);
        wr24(5, 24'h111111);
        wr24(7, 24'h222222);
        rdb(5, 0); rdb(6, 1); rdb(2, 3); rdb(0, 3);
        rdb(2, 0); rdb(3, 0); rdb(4, 0);

        // R9: live commit together with a pulse that would wrap
        cur_req = "R9";
        wr24(2, 24'h000010);
        wr24(0, 24'h00000F);
        wrb(0, 0, 8'h05);
        wrb(0, 1, 8'h00);
        tick = 1'b1;
        wrb(0, 2, 8'h00);
        tick = 1'b0;
        rdb(0, 0);
        run(12, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule